// File: doc/BRIEF.md
# Bidirectional Latch-Register Bus Transceiver

This block carries an 18-bit word between an A port and a B port in both directions. Data is never inverted. Each direction has its own storage element, which works in one of two ways. While its pass-through control is high, it behaves like an open latch. While that control is low, it behaves like an edge-triggered register that loads on a rising edge of its own strobe. A clock-enable gates that strobe.

Each direction also has an active-low output enable. In this synthesizable form the enable becomes a separate drive-enable flag next to the output word, so a pad ring or bus mux at a higher level can decide what reaches the wire. The two directions share only the system clock and reset and do not interact.

The strobe and all controls are sampled on the system clock. A strobe edge is a cycle in which the strobe reads high after reading low on the previous system clock edge.

Top module: `bus_xcvr18`

## Requirements
- R1: While `rst` is high, both drive-enable flags are 0. After a reset cycle, both stored words are zero, so with pass-through low and no strobe edge both output words read 0.
- R2: While a direction's pass-through control is 1, its output word equals its input word in the same cycle, bit for bit and not inverted.
- R3: While pass-through is 0 and no qualified strobe edge occurs, the output word keeps its value whatever the input does. This includes a strobe held steady high or steady low.
- R4: With pass-through 0 and clock-enable 0, a strobe that reads 1 after reading 0 at the previous system clock edge loads the input word. The loaded word appears on the output after that edge.
- R5: While the clock-enable is 1, a strobe rising edge does not change the output word.
- R6: When pass-through falls from 1 to 0, the output keeps the input word sampled at the last system clock edge at which pass-through was 1. It holds that word until the next qualified strobe edge.
- R7: Outside reset, a direction's drive-enable is 1 exactly when its active-low output enable is 0. The output enable does not change the stored word.
- R8: The A-to-B controls and data have no effect on the B-to-A output, and the B-to-A controls and data have no effect on the A-to-B output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Word arriving at the A side |
| ab_pass | input | 1 | A-to-B pass-through control, 1 = transparent |
| ab_strobe | input | 1 | A-to-B capture strobe, sampled level |
| ab_ce_n | input | 1 | A-to-B strobe enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| b_out | output | 18 | Word presented to the B side |
| b_drv | output | 1 | B-side drive-enable |
| b_in | input | 18 | Word arriving at the B side |
| ba_pass | input | 1 | B-to-A pass-through control, 1 = transparent |
| ba_strobe | input | 1 | B-to-A capture strobe, sampled level |
| ba_ce_n | input | 1 | B-to-A strobe enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_out | output | 18 | Word presented to the A side |
| a_drv | output | 1 | A-side drive-enable |

## Verification
The embedded properties follow the stored word on every cycle. They check that it clears after reset and tracks the input while transparent. They check that it stays stable without a qualified edge or while the strobe enable is off, and that it loads the input on a qualified edge. They also check that a detected strobe edge lasts exactly one cycle and that reset keeps the drive flags off.

Some behaviour can only be seen at the output ports and over a planned sequence, so the bench scenarios cover it. These include the word frozen when pass-through falls, a strobe held high that must not reload, a rising edge masked by the clock-enable, and the isolation of one direction from the other direction's traffic.

// File: rtl/bxv_pkg.sv
package bxv_pkg;

    localparam int unsigned LANE_W = 18;

    typedef logic [LANE_W-1:0] word_t;

    typedef struct packed {
        logic pass;
        logic strobe;
        logic ce_n;
        logic oe_n;
    } lane_ctl_t;

    function automatic logic load_now(input lane_ctl_t ctl, input logic rise);
        return (!ctl.pass) && (!ctl.ce_n) && rise;
    endfunction

endpackage

// File: rtl/bxv_rise_det.sv
module bxv_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= lvl;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/bxv_lane.sv
module bxv_lane
    import bxv_pkg::*;
#(
    parameter int unsigned W = LANE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  lane_ctl_t    ctl,
    output logic [W-1:0] dout,
    output logic         drv
);
    logic [W-1:0] held;
    logic         rise;
    logic         take;

    bxv_rise_det u_rise (
        .clk  (clk),
        .rst  (rst),
        .lvl  (ctl.strobe),
        .rise (rise)
    );

    assign take = load_now(ctl, rise);

    always_ff @(posedge clk) begin
        if (rst)           held <= '0;
        else if (ctl.pass) held <= din;
        else if (take)     held <= din;
    end

    assign dout = ctl.pass ? din : held;
    assign drv  = (!ctl.oe_n) && (!rst);

    // R1
    held_clear_chk: assert property (@(posedge clk)
        rst |=> (held == '0));

    // R1
    always_comb begin
        if (rst === 1'b1) begin
            drv_off_in_reset_chk: assert (drv == 1'b0);
        end
    end

    // R6
    follow_while_open_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.pass |=> (held == $past(din)));

    // R3
    hold_no_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.pass && !rise) |=> $stable(held));

    // R5
    hold_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.pass && ctl.ce_n) |=> $stable(held));

    // R4
    load_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.pass && !ctl.ce_n && rise) |=> (held == $past(din)));

endmodule

// File: rtl/bus_xcvr18.sv
module bus_xcvr18
    import bxv_pkg::*;
#(
    parameter int unsigned W = LANE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic         ab_pass,
    input  logic         ab_strobe,
    input  logic         ab_ce_n,
    input  logic         ab_oe_n,
    output logic [W-1:0] b_out,
    output logic         b_drv,
    input  logic [W-1:0] b_in,
    input  logic         ba_pass,
    input  logic         ba_strobe,
    input  logic         ba_ce_n,
    input  logic         ba_oe_n,
    output logic [W-1:0] a_out,
    output logic         a_drv
);
    localparam int unsigned NDIR = 2;

    lane_ctl_t    ctl  [NDIR];
    logic [W-1:0] din  [NDIR];
    logic [W-1:0] dout [NDIR];
    logic         drv  [NDIR];

    assign ctl[0] = '{pass: ab_pass, strobe: ab_strobe, ce_n: ab_ce_n, oe_n: ab_oe_n};
    assign ctl[1] = '{pass: ba_pass, strobe: ba_strobe, ce_n: ba_ce_n, oe_n: ba_oe_n};
    assign din[0] = a_in;
    assign din[1] = b_in;

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        bxv_lane #(.W(W)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .din  (din[g]),
            .ctl  (ctl[g]),
            .dout (dout[g]),
            .drv  (drv[g])
        );
    end

    assign b_out = dout[0];
    assign b_drv = drv[0];
    assign a_out = dout[1];
    assign a_drv = drv[1];

endmodule

// File: tb/bus_xcvr18_bench.sv
module bus_xcvr18_bench;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         ab_pass = 1'b0, ab_strobe = 1'b0, ab_ce_n = 1'b0, ab_oe_n = 1'b1;
    logic         ba_pass = 1'b0, ba_strobe = 1'b0, ba_ce_n = 1'b0, ba_oe_n = 1'b1;
    logic [W-1:0] b_out, a_out;
    logic         b_drv, a_drv;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bus_xcvr18 u_bus_xcvr18 (
        .clk(clk), .rst(rst),
        .a_in(a_in), .ab_pass(ab_pass), .ab_strobe(ab_strobe), .ab_ce_n(ab_ce_n), .ab_oe_n(ab_oe_n),
        .b_out(b_out), .b_drv(b_drv),
        .b_in(b_in), .ba_pass(ba_pass), .ba_strobe(ba_strobe), .ba_ce_n(ba_ce_n), .ba_oe_n(ba_oe_n),
        .a_out(a_out), .a_drv(a_drv)
    );

    // pass, strobe, ce_n, oe_n, a_in, expected b_out, expected b_drv, requirement
    typedef struct packed {
        logic         pass;
        logic         strobe;
        logic         ce_n;
        logic         oe_n;
        logic [W-1:0] din;
        logic [W-1:0] exp_q;
        logic         exp_drv;
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 18'h12345, 18'h12345, 1'b1, 4'd2},
        '{1'b1, 1'b0, 1'b0, 1'b0, 18'h2AAAA, 18'h2AAAA, 1'b1, 4'd2},
        '{1'b0, 1'b0, 1'b0, 1'b0, 18'h15555, 18'h2AAAA, 1'b1, 4'd6},
        '{1'b0, 1'b0, 1'b0, 1'b0, 18'h00F0F, 18'h2AAAA, 1'b1, 4'd3},
        '{1'b0, 1'b1, 1'b0, 1'b0, 18'h00F0F, 18'h00F0F, 1'b1, 4'd4},
        '{1'b0, 1'b1, 1'b0, 1'b0, 18'h3FFFF, 18'h00F0F, 1'b1, 4'd3},
        '{1'b0, 1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h00F0F, 1'b1, 4'd3},
        '{1'b0, 1'b1, 1'b1, 1'b0, 18'h3FFFF, 18'h00F0F, 1'b1, 4'd5},
        '{1'b0, 1'b0, 1'b0, 1'b1, 18'h3FFFF, 18'h00F0F, 1'b0, 4'd7},
        '{1'b0, 1'b1, 1'b0, 1'b1, 18'h3FFFF, 18'h3FFFF, 1'b0, 4'd4},
        '{1'b0, 1'b1, 1'b0, 1'b0, 18'h00001, 18'h3FFFF, 1'b1, 4'd3},
        '{1'b1, 1'b0, 1'b0, 1'b0, 18'h00001, 18'h00001, 1'b1, 4'd2}
    };

    task automatic check_word(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        ab_oe_n = 1'b0;
        ba_oe_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: drive flags off during reset despite enabled outputs
        check_bit("R1 b_drv in reset", b_drv, 1'b0);
        check_bit("R1 a_drv in reset", a_drv, 1'b0);
        rst = 1'b0;
        a_in = 18'h3FFFF;
        b_in = 18'h3FFFF;
        @(posedge clk);
        @(negedge clk);
        // R1: cleared store visible with pass low and no edge
        check_word("R1 b_out after reset", b_out, '0);
        check_word("R1 a_out after reset", a_out, '0);
        // R7
        check_bit("R7 b_drv enabled", b_drv, 1'b1);

        for (int i = 0; i < NV; i++) begin
            ab_pass   = VEC[i].pass;
            ab_strobe = VEC[i].strobe;
            ab_ce_n   = VEC[i].ce_n;
            ab_oe_n   = VEC[i].oe_n;
            a_in      = VEC[i].din;
            @(posedge clk);
            @(negedge clk);
            check_word($sformatf("R%0d vec %0d b_out", VEC[i].req, i), b_out, VEC[i].exp_q);
            check_bit($sformatf("R%0d vec %0d b_drv", VEC[i].req, i), b_drv, VEC[i].exp_drv);
            // R8: B-to-A side kept still, its output untouched by A-to-B traffic
            check_word($sformatf("R8 vec %0d a_out", i), a_out, '0);
        end

        // R8: freeze A-to-B, then exercise B-to-A
        ab_pass = 1'b0;
        ab_strobe = 1'b0;
        a_in = 18'h0F0F0;
        @(negedge clk);
        ba_pass = 1'b1;
        b_in = 18'h3C3C3;
        @(posedge clk);
        @(negedge clk);
        check_word("R2 a_out transparent", a_out, 18'h3C3C3);
        check_word("R8 b_out unaffected", b_out, 18'h00001);
        ba_pass = 1'b0;
        b_in = 18'h11111;
        @(posedge clk);
        @(negedge clk);
        check_word("R6 a_out frozen", a_out, 18'h3C3C3);
        ba_strobe = 1'b1;
        b_in = 18'h22222;
        @(posedge clk);
        @(negedge clk);
        check_word("R4 a_out captured", a_out, 18'h22222);
        check_word("R8 b_out after ba edge", b_out, 18'h00001);
        ba_oe_n = 1'b1;
        #1;
        check_bit("R7 a_drv off", a_drv, 1'b0);
        check_word("R7 a_out kept", a_out, 18'h22222);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule